// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns a 16-bit unsigned binary number into five 4-bit decimal digits. It reuses one bit-serial restoring divider that divides by ten. Each division produces one quotient bit per clock. After 16 bit-steps the remainder is the lowest decimal digit still to be produced, and the quotient becomes the dividend of the next division. Five divisions give all five digits, from the ones digit up to the ten-thousands digit.

A level-held start input controls the block. While start is low the block sits cleared. On the first clock edge that sees start high, the block captures the input value. It then runs without further input and raises ready once all five digits are stored. Ready and the digit vector hold until start is pulled low again. Pulling start low at any point aborts the conversion and clears the block.

Top module: `bin2dec_seq`

## Requirements
- R1: A clock edge that samples `start` low clears the block. After that edge `ready` is 0 and every bit of `digitsOut` is 0.
- R2: `binValue` is captured only on the first clock edge that samples `start` high after a cleared state. Changes to `binValue` after that edge do not change the result.
- R3: `ready` first reads 1 after exactly 86 rising edges, counting the capture edge as edge 1. This is one capture edge plus five divisions of 16 bit-steps and one store step each. `ready` is 0 after every earlier edge.
- R4: When `ready` is 1, `digitsOut[4k+3:4k]` holds decimal digit k of the captured value in plain binary (0 to 9). Digit 0 is the ones digit in bits [3:0] and digit 4 is the ten-thousands digit in bits [19:16].
- R5: The largest input, 65535, converts to digits 6,5,5,3,5 (bits [19:0] = 20'h65535).
- R6: An input of 0 converts to five zero digits.
- R7: While `start` stays high after `ready` has risen, `ready` stays 1 and `digitsOut` does not change.
- R8: Pulling `start` low in the middle of a conversion aborts it, as set out in R1. A later start then produces the correct digits for the newly captured value.
- R9: Each division step follows restoring shift-and-subtract. The partial remainder takes in the next dividend bit, MSB first, and ten is subtracted when the shifted value is at least ten. The partial remainder therefore never reaches ten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| start | input | 1 | Level request; low clears, high runs one conversion and holds the result |
| binValue | input | 16 | Unsigned binary value, sampled on the capture edge |
| ready | output | 1 | High once all five digits are stored, until start falls |
| digitsOut | output | 20 | Five packed 4-bit decimal digits, ones digit lowest |

## Verification
The embedded properties check on every cycle that the partial remainder stays below ten and that every digit is at most nine once ready is up. They also check that ready rises only straight out of a store step, that a fresh start finds ready low, and that ready and the digits stay frozen while start stays high. These properties cannot show that the digits are the right decimal expansion, that the latency is exactly 86 edges, that a mid-run abort leaves nothing behind, or that later changes to the input are ignored. The bench's scenarios cover those: directed extremes and random values compared against a reference expansion computed in the bench.

// File: rtl/bin2dec_pkg.sv
package bin2dec_pkg;
  // strobes issued by the sequencer to the divider datapath
  typedef struct packed {
    logic clearAll;  // start low: wipe partial results and digits
    logic load;      // capture the input as the first dividend
    logic shift;     // one restoring shift-subtract step
    logic store;     // file remainder as a digit, quotient becomes dividend
  } stepCmd_t;

  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_ITER  = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } ctrlState_t;
endpackage

// File: rtl/bin2dec_ctrl.sv
module bin2dec_ctrl
  import bin2dec_pkg::*;
#(
  parameter int VALUE_W    = 16,
  parameter int NUM_DIGITS = 5,
  localparam int CNT_W = $clog2(VALUE_W),
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk,
  input  logic             start,
  output stepCmd_t         cmd,
  output logic [IDX_W-1:0] digitIdx,
  output logic             ready
);
  ctrlState_t state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!start) begin
      state    <= ST_ARM;
      bitCnt   <= '0;
      digitIdx <= '0;
      ready    <= 1'b0;
    end else begin
      case (state)
        ST_ARM: begin
          state    <= ST_ITER;
          bitCnt   <= '0;
          digitIdx <= '0;
        end
        ST_ITER: begin
          if (bitCnt == CNT_W'(VALUE_W - 1)) begin
            state  <= ST_STORE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STORE: begin
          if (digitIdx == IDX_W'(NUM_DIGITS - 1)) begin
            state <= ST_DONE;
            ready <= 1'b1;
          end else begin
            digitIdx <= digitIdx + 1'b1;
            state    <= ST_ITER;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.clearAll = !start;
    cmd.load     = start && (state == ST_ARM);
    cmd.shift    = start && (state == ST_ITER);
    cmd.store    = start && (state == ST_STORE);
  end

  // R3: completion only ever follows the final store step
  assert_ready_after_store_R3: assert property (@(posedge clk) disable iff (!start)
    $rose(ready) |-> $past(state) == ST_STORE);

  // R1: a newly raised start always finds the block cleared and armed
  assert_start_finds_clear_R1: assert property (@(posedge clk) disable iff (!start)
    $rose(start) |-> (!ready && state == ST_ARM));
endmodule

// File: rtl/bin2dec_datapath.sv
module bin2dec_datapath
  import bin2dec_pkg::*;
#(
  parameter int VALUE_W    = 16,
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W    = 4,
  parameter int RADIX      = 10,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int REM_W = $clog2(RADIX),
  localparam int OUT_W = NUM_DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  stepCmd_t           cmd,
  input  logic [IDX_W-1:0]   digitIdx,
  input  logic [VALUE_W-1:0] binValue,
  output logic [OUT_W-1:0]   digitsOut
);
  logic [VALUE_W-1:0] dividend;
  logic [VALUE_W-1:0] quotient;
  logic [REM_W-1:0]   partRem;
  logic [REM_W:0]     shiftedRem;
  logic               takeSub;

  assign shiftedRem = {partRem, dividend[VALUE_W-1]};
  assign takeSub    = shiftedRem >= (REM_W+1)'(RADIX);

  always_ff @(posedge clk) begin
    if (cmd.clearAll) begin
      partRem  <= '0;
      quotient <= '0;
    end else if (cmd.load) begin
      dividend <= binValue;
      partRem  <= '0;
      quotient <= '0;
    end else if (cmd.shift) begin
      partRem  <= takeSub ? REM_W'(shiftedRem - (REM_W+1)'(RADIX))
                          : shiftedRem[REM_W-1:0];
      quotient <= {quotient[VALUE_W-2:0], takeSub};
      dividend <= dividend << 1;
    end else if (cmd.store) begin
      dividend <= quotient;
      partRem  <= '0;
      quotient <= '0;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gSlot
    logic [DIGIT_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (cmd.clearAll)
        slot <= '0;
      else if (cmd.store && digitIdx == IDX_W'(g))
        slot <= DIGIT_W'(partRem);
    end
    assign digitsOut[g*DIGIT_W +: DIGIT_W] = slot;
  end

  // R9: restoring step keeps the partial remainder below the radix
  assert_rem_below_radix_R9: assert property (@(posedge clk) disable iff (!cmd.shift && !cmd.store)
    partRem < REM_W'(RADIX));
endmodule

// File: rtl/bin2dec_seq.sv
module bin2dec_seq
  import bin2dec_pkg::*;
#(
  parameter int VALUE_W    = 16,
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W    = 4,
  parameter int RADIX      = 10,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int OUT_W = NUM_DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  logic               start,
  input  logic [VALUE_W-1:0] binValue,
  output logic               ready,
  output logic [OUT_W-1:0]   digitsOut
);
  stepCmd_t         cmd;
  logic [IDX_W-1:0] digitIdx;

  bin2dec_ctrl #(.VALUE_W(VALUE_W), .NUM_DIGITS(NUM_DIGITS)) uCtrl (
    .clk(clk), .start(start), .cmd(cmd), .digitIdx(digitIdx), .ready(ready)
  );

  bin2dec_datapath #(.VALUE_W(VALUE_W), .NUM_DIGITS(NUM_DIGITS),
                     .DIGIT_W(DIGIT_W), .RADIX(RADIX)) uPath (
    .clk(clk), .cmd(cmd), .digitIdx(digitIdx), .binValue(binValue),
    .digitsOut(digitsOut)
  );

  // R7: finished result is frozen while start stays high
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!start)
    ready |=> (ready && $stable(digitsOut)));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigitChk
    // R4: every delivered digit is a decimal digit
    assert_digit_decimal_R4: assert property (@(posedge clk) disable iff (!start)
      ready |-> digitsOut[g*DIGIT_W +: DIGIT_W] < DIGIT_W'(RADIX));
  end
endmodule

// File: tb/bin2dec_seq_test.sv
`timescale 1ns/1ps
module bin2dec_seq_test;
  localparam int LAT = 1 + 5 * (16 + 1);

  logic        clk = 1'b0;
  logic        start = 1'b0;
  logic [15:0] binValue = '0;
  logic        ready;
  logic [19:0] digitsOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bin2dec_seq uut (.clk(clk), .start(start), .binValue(binValue),
                   .ready(ready), .digitsOut(digitsOut));

  function automatic logic [19:0] refDigits(input logic [15:0] v);
    int rest = v;
    logic [19:0] r = '0;
    for (int k = 0; k < 5; k++) begin
      r[k*4 +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dropAndCheck(input string req);
    start = 1'b0;
    tick();
    check(ready == 1'b0, req, ready, 0);
    check(digitsOut == 20'h0, req, digitsOut, 0);
  endtask

  task automatic convert(input logic [15:0] v, input string req);
    int n = 0;
    logic [19:0] exp = refDigits(v);
    logic [19:0] held;
    binValue = v;
    start = 1'b1;
    tick();
    n = 1;
    binValue = 16'($urandom);  // R2: later input changes must be ignored
    while (!ready && n < 200) begin
      tick();
      n++;
    end
    check(n == LAT, "R3 latency", n, LAT);
    check(digitsOut == exp, req, digitsOut, exp);
    held = digitsOut;
    for (int i = 0; i < 5; i++) begin
      binValue = 16'($urandom);
      tick();
    end
    check(ready == 1'b1, "R7 ready hold", ready, 1);
    check(digitsOut == held, "R7 digits hold", digitsOut, held);
    dropAndCheck("R1 clear after done");
  endtask

  initial begin
    void'($urandom(32'h5EED_0B1D));
    for (int i = 0; i < 4; i++) tick();
    check(ready == 1'b0, "R1 reset ready", ready, 0);
    check(digitsOut == 20'h0, "R1 reset digits", digitsOut, 0);

    convert(16'd0, "R6 zero input");
    convert(16'd65535, "R5 max input");
    check(refDigits(16'd65535) == 20'h65535, "R5 ref", refDigits(16'd65535), 20'h65535);
    convert(16'd12345, "R4 digit order");
    convert(16'd9, "R4 single digit");
    convert(16'd10, "R4 carry to tens");
    convert(16'd10000, "R4 top digit");
    convert(16'd59999, "R2 capture/R4 nines");

    // R8: abort mid-conversion, then restart with a new value
    binValue = 16'd43210;
    start = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    check(ready == 1'b0, "R8 not ready mid-run", ready, 0);
    dropAndCheck("R8 abort clears");
    convert(16'd7, "R8 restart result");

    for (int t = 0; t < 40; t++) convert(16'($urandom), "R4 random value");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule